// File: doc/BRIEF.md
# Load-Queue Memory Ordering Checker

This block sits beside the circular load queue of an out-of-order core and finds memory ordering violations. It keeps a small shadow record for every load-queue slot: the address range and sequence number of the load that executed there, plus four flags (executed, strictly ordered, hit by an external snoop, possible violation). Each executing load or store is compared against the younger loads that have already executed. Each incoming cache-line invalidation is compared against all live loads. When a violation is found, the block raises a re-execute request and names the oldest offending load by slot index and sequence number.

Addresses are compared at a coarse granularity. Both ends of every range are shifted right by `GRAN_SHIFT` bits before the comparison, so two accesses that touch the same block count as overlapping. A load that runs ahead of an older load to the same block is not an error on its own. It is only marked as a possible violation. It turns into a real violation if an invalidation of its line arrives while it holds that mark, or if an older overlapping load executes after the snoop flag has been set. The pipeline reads the violator with an acknowledge pulse, and a flush wipes all state.

Top module: `lqc_order_check`

## Requirements
- R1: Overlap is decided on addresses shifted right by GRAN_SHIFT (default 3). Ranges that differ only below that bit position overlap.
- R2: An executing range [lo,hi] overlaps a recorded load [llo,lhi] when hi>>GRAN_SHIFT >= llo>>GRAN_SHIFT and lo>>GRAN_SHIFT <= lhi>>GRAN_SHIFT. Both bounds are inclusive.
- R3: A slot whose load has not yet executed since reset, flush or allocation is never checked. Neither is a slot whose load executed with ex_strict_i=1.
- R4: When a load (ex_kind_i=0) executes and overlaps a younger executed load, it is a violation if that younger load's snoop flag is set. If the flag is clear, the younger load is only marked as a possible violation and reexec_o stays low.
- R5: When a store (ex_kind_i=1) executes, every overlapping executed load at a queue position at or after ex_ptr_i is a violation. Loads at positions before ex_ptr_i are not.
- R6: Only the oldest violator is held on viol_idx_o/viol_seq_o. A new violator replaces the held one only if its sequence number is older under wrap-safe comparison (the MSB of new-minus-held is 1). When several candidates arise in one cycle, the oldest of them wins.
- R7: A snoop (snp_valid_i) whose line number equals address bits [ADDR_W-1:LINE_SHIFT] of a live, checkable load sets that load's snoop flag. If the load was already marked as a possible violation, it becomes a violator.
- R8: While chk_en_i is 0, executes raise no violation and change no flags, and snoops are ignored. Loads are still recorded.
- R9: viol_ack_i clears the held violator unless a new one arrives in the same cycle, in which case the new one is held whatever its age. flush_i clears the violator and every slot record.
- R10: After reset, reexec_o is 0 and no slot is checkable.
- R11: Only slots between lq_head_i and lq_tail_i are live. These pointers carry one wrap bit above the slot index. alloc_i clears the record of slot lq_tail_i.
- R12: Every result appears on reexec_o/viol_idx_o/viol_seq_o on the clock edge after the triggering input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| chk_en_i | input | 1 | Enables ordering checks and snoop handling |
| flush_i | input | 1 | Clears all slot records and the violator |
| alloc_i | input | 1 | Clears the record of slot lq_tail_i |
| lq_head_i | input | IDX_W+1 | Load queue head pointer with wrap bit |
| lq_tail_i | input | IDX_W+1 | Load queue tail pointer with wrap bit |
| ex_valid_i | input | 1 | An access executes this cycle |
| ex_kind_i | input | 1 | 0 load, 1 store |
| ex_strict_i | input | 1 | Executing load is strictly ordered |
| ex_ptr_i | input | IDX_W+1 | Load: its own slot pointer. Store: pointer of the first load younger than it |
| ex_seq_i | input | SEQ_W | Sequence number of the executing access |
| ex_lo_i | input | ADDR_W | First byte address |
| ex_hi_i | input | ADDR_W | Last byte address |
| snp_valid_i | input | 1 | Invalidation arrives |
| snp_line_i | input | ADDR_W-LINE_SHIFT | Invalidated line number |
| viol_ack_i | input | 1 | Pipeline has read the violator |
| reexec_o | output | 1 | Re-execute request (a violator is held) |
| viol_idx_o | output | IDX_W | Slot of the oldest violating load |
| viol_seq_o | output | SEQ_W | Sequence number of the oldest violating load |

## Verification
A wrong flag bit in a slot stays hidden until a later access hits that slot. A lost snoop flag or possible-violation mark shows up only when a second, older overlapping load or a snoop of the same line arrives. Then reexec_o stays low one edge after the input that should have raised it. Because of this, the tests build each flag state with one access and expose it with a second. A wrong age choice shows at once as the wrong viol_idx_o/viol_seq_o on the edge after the competing violator arrives, including across sequence wrap. Stale records outside the live window show as spurious re-execute requests.

// File: rtl/lqc_pkg.sv
package lqc_pkg;

    typedef enum logic {
        ACC_LOAD  = 1'b0,
        ACC_STORE = 1'b1
    } acc_kind_e;

    typedef struct packed {
        logic written;
        logic strict;
        logic snoop_hit;
        logic poss_viol;
    } lq_flags_t;

    localparam lq_flags_t FLAGS_EMPTY = '{written: 1'b0, strict: 1'b0,
                                          snoop_hit: 1'b0, poss_viol: 1'b0};

endpackage

// File: rtl/lqc_range_mask.sv
// Slot liveness and "at or after the executing position" masks for a circular queue.
module lqc_range_mask #(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [IDX_W:0]    head_i,
    input  logic [IDX_W:0]    tail_i,
    input  logic [IDX_W:0]    from_i,
    input  logic              incl_i,
    output logic [DEPTH-1:0]  live_o,
    output logic [DEPTH-1:0]  younger_o
);
    logic [IDX_W:0] occ;
    logic [IDX_W:0] from_d;

    assign occ    = tail_i - head_i;
    assign from_d = from_i - head_i;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [IDX_W-1:0] d_low;
        logic [IDX_W:0]   d;
        assign d_low        = IDX_W'(g) - head_i[IDX_W-1:0];
        assign d            = {1'b0, d_low};
        assign live_o[g]    = (d < occ);
        assign younger_o[g] = live_o[g] && (incl_i ? (d >= from_d) : (d > from_d));
    end
endmodule

// File: rtl/lqc_oldest_pick.sv
// Picks the request with the oldest sequence number, wrap-safe.
module lqc_oldest_pick #(
    parameter int DEPTH = 8,
    parameter int SEQ_W = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] req_i,
    input  logic [SEQ_W-1:0] seq_i [DEPTH],
    output logic             valid_o,
    output logic [IDX_W-1:0] idx_o,
    output logic [SEQ_W-1:0] seq_o
);
    logic [SEQ_W-1:0] diff;

    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        seq_o   = '0;
        diff    = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (req_i[i]) begin
                diff = seq_i[i] - seq_o;
                if (!valid_o || diff[SEQ_W-1]) begin
                    valid_o = 1'b1;
                    idx_o   = IDX_W'(i);
                    seq_o   = seq_i[i];
                end
            end
        end
    end
endmodule

// File: rtl/lqc_order_check.sv
module lqc_order_check
    import lqc_pkg::*;
#(
    parameter int DEPTH      = 8,
    parameter int ADDR_W     = 32,
    parameter int SEQ_W      = 16,
    parameter int GRAN_SHIFT = 3,
    parameter int LINE_SHIFT = 6,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int LINE_W = ADDR_W - LINE_SHIFT
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              chk_en_i,
    input  logic              flush_i,
    input  logic              alloc_i,
    input  logic [IDX_W:0]    lq_head_i,
    input  logic [IDX_W:0]    lq_tail_i,
    input  logic              ex_valid_i,
    input  logic              ex_kind_i,
    input  logic              ex_strict_i,
    input  logic [IDX_W:0]    ex_ptr_i,
    input  logic [SEQ_W-1:0]  ex_seq_i,
    input  logic [ADDR_W-1:0] ex_lo_i,
    input  logic [ADDR_W-1:0] ex_hi_i,
    input  logic              snp_valid_i,
    input  logic [LINE_W-1:0] snp_line_i,
    input  logic              viol_ack_i,
    output logic              reexec_o,
    output logic [IDX_W-1:0]  viol_idx_o,
    output logic [SEQ_W-1:0]  viol_seq_o
);
    acc_kind_e        ex_kind;
    logic             is_store;
    logic             is_load_wr;
    logic             exec_chk;
    logic             snp_chk;
    logic [IDX_W-1:0] ex_slot;
    logic [IDX_W-1:0] tail_slot;
    logic [ADDR_W-1:0] ex_lo_g;
    logic [ADDR_W-1:0] ex_hi_g;

    assign ex_kind    = acc_kind_e'(ex_kind_i);
    assign is_store   = (ex_kind == ACC_STORE);
    assign is_load_wr = ex_valid_i && !is_store;
    assign exec_chk   = chk_en_i && ex_valid_i;
    assign snp_chk    = chk_en_i && snp_valid_i;
    assign ex_slot    = ex_ptr_i[IDX_W-1:0];
    assign tail_slot  = lq_tail_i[IDX_W-1:0];
    assign ex_lo_g    = ex_lo_i >> GRAN_SHIFT;
    assign ex_hi_g    = ex_hi_i >> GRAN_SHIFT;

    // Slot records
    lq_flags_t         flags_q [DEPTH];
    logic [ADDR_W-1:0] lo_q    [DEPTH];
    logic [ADDR_W-1:0] hi_q    [DEPTH];
    logic [SEQ_W-1:0]  seq_q   [DEPTH];

    // Position masks
    logic [DEPTH-1:0] live;
    logic [DEPTH-1:0] younger;

    lqc_range_mask #(.DEPTH(DEPTH)) u_range (
        .head_i    (lq_head_i),
        .tail_i    (lq_tail_i),
        .from_i    (ex_ptr_i),
        .incl_i    (is_store),
        .live_o    (live),
        .younger_o (younger)
    );

    // Per-slot comparisons
    logic [DEPTH-1:0] ex_viol;
    logic [DEPTH-1:0] ex_mark;
    logic [DEPTH-1:0] snp_hit;
    logic [DEPTH-1:0] snp_viol;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        logic usable;
        logic ovl;
        logic ex_hit;
        logic [ADDR_W-1:0] ld_lo_g;
        logic [ADDR_W-1:0] ld_hi_g;
        assign ld_lo_g     = lo_q[g] >> GRAN_SHIFT;
        assign ld_hi_g     = hi_q[g] >> GRAN_SHIFT;
        assign usable      = flags_q[g].written && !flags_q[g].strict;
        assign ovl         = (ex_hi_g >= ld_lo_g) && (ex_lo_g <= ld_hi_g);
        assign ex_hit      = exec_chk && younger[g] && usable && ovl;
        assign ex_viol[g]  = ex_hit && (is_store || flags_q[g].snoop_hit);
        assign ex_mark[g]  = ex_hit && !is_store && !flags_q[g].snoop_hit;
        assign snp_hit[g]  = snp_chk && live[g] && usable &&
                             (lo_q[g][ADDR_W-1:LINE_SHIFT] == snp_line_i);
        assign snp_viol[g] = snp_hit[g] && flags_q[g].poss_viol;
    end

    // Flag state
    always_ff @(posedge clk_i) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (rst_i || flush_i) begin
                flags_q[i] <= FLAGS_EMPTY;
            end else if (is_load_wr && ex_slot == IDX_W'(i)) begin
                flags_q[i] <= '{written: 1'b1, strict: ex_strict_i,
                                snoop_hit: 1'b0, poss_viol: 1'b0};
            end else if (alloc_i && tail_slot == IDX_W'(i)) begin
                flags_q[i] <= FLAGS_EMPTY;
            end else begin
                if (ex_mark[i]) flags_q[i].poss_viol <= 1'b1;
                if (snp_hit[i]) flags_q[i].snoop_hit <= 1'b1;
            end
        end
    end

    // Address and age storage (qualified by the written flag)
    always_ff @(posedge clk_i) begin
        if (is_load_wr) begin
            lo_q[ex_slot]  <= ex_lo_i;
            hi_q[ex_slot]  <= ex_hi_i;
            seq_q[ex_slot] <= ex_seq_i;
        end
    end

    // Oldest candidate this cycle
    logic             cand_v;
    logic [IDX_W-1:0] cand_idx;
    logic [SEQ_W-1:0] cand_seq;

    lqc_oldest_pick #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) u_pick (
        .req_i   (ex_viol | snp_viol),
        .seq_i   (seq_q),
        .valid_o (cand_v),
        .idx_o   (cand_idx),
        .seq_o   (cand_seq)
    );

    // Held violator
    logic             viol_v_q;
    logic [IDX_W-1:0] viol_idx_q;
    logic [SEQ_W-1:0] viol_seq_q;
    logic [SEQ_W-1:0] age_diff;
    logic             take_new;

    assign age_diff = cand_seq - viol_seq_q;
    assign take_new = cand_v && (!viol_v_q || viol_ack_i || age_diff[SEQ_W-1]);

    always_ff @(posedge clk_i) begin
        if (rst_i || flush_i) begin
            viol_v_q   <= 1'b0;
            viol_idx_q <= '0;
            viol_seq_q <= '0;
        end else if (take_new) begin
            viol_v_q   <= 1'b1;
            viol_idx_q <= cand_idx;
            viol_seq_q <= cand_seq;
        end else if (viol_ack_i) begin
            viol_v_q   <= 1'b0;
        end
    end

    assign reexec_o   = viol_v_q;
    assign viol_idx_o = viol_idx_q;
    assign viol_seq_o = viol_seq_q;
endmodule

// File: rtl/lqc_order_check_sva.sv
module lqc_order_check_sva #(
    parameter int SEQ_W = 16
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             chk_en_i,
    input logic             flush_i,
    input logic             ex_valid_i,
    input logic             snp_valid_i,
    input logic             viol_ack_i,
    input logic             reexec_o,
    input logic [SEQ_W-1:0] viol_seq_o
);
    logic [SEQ_W-1:0] prev_seq_q;
    logic [SEQ_W-1:0] seq_step;

    always_ff @(posedge clk_i) prev_seq_q <= viol_seq_o;
    assign seq_step = viol_seq_o - prev_seq_q;

    assert_reset_idle_R10: assert property (@(posedge clk_i)
        rst_i |=> !reexec_o);

    assert_flush_clears_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        flush_i |=> !reexec_o);

    assert_ack_clears_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        viol_ack_i && !ex_valid_i && !snp_valid_i |=> !reexec_o);

    assert_disabled_quiet_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        !chk_en_i && (!reexec_o || viol_ack_i) |=> !reexec_o);

    assert_keep_older_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        reexec_o && !viol_ack_i && !flush_i
        |=> reexec_o && (seq_step == '0 || seq_step[SEQ_W-1]));

    assert_hold_idle_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        reexec_o && !viol_ack_i && !flush_i && !ex_valid_i && !snp_valid_i
        |=> reexec_o && $stable(viol_seq_o));
endmodule

bind lqc_order_check lqc_order_check_sva #(.SEQ_W(SEQ_W)) u_sva (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .chk_en_i    (chk_en_i),
    .flush_i     (flush_i),
    .ex_valid_i  (ex_valid_i),
    .snp_valid_i (snp_valid_i),
    .viol_ack_i  (viol_ack_i),
    .reexec_o    (reexec_o),
    .viol_seq_o  (viol_seq_o)
);

// File: tb/test_lqc_order_check.sv
`timescale 1ns/1ps
module test_lqc_order_check;
    localparam int DEPTH = 8;
    localparam int IDX_W = 3;
    localparam int SEQ_W = 16;
    localparam int ADDR_W = 32;
    localparam int LINE_W = 26;

    logic clk = 1'b0;
    logic rst, chk_en, flush, alloc;
    logic [IDX_W:0] head, tail;
    logic ex_valid, ex_kind, ex_strict;
    logic [IDX_W:0] ex_ptr;
    logic [SEQ_W-1:0] ex_seq;
    logic [ADDR_W-1:0] ex_lo, ex_hi;
    logic snp_valid;
    logic [LINE_W-1:0] snp_line;
    logic viol_ack;
    logic reexec;
    logic [IDX_W-1:0] viol_idx;
    logic [SEQ_W-1:0] viol_seq;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    lqc_order_check i_lqc_order_check (
        .clk_i(clk), .rst_i(rst), .chk_en_i(chk_en), .flush_i(flush), .alloc_i(alloc),
        .lq_head_i(head), .lq_tail_i(tail),
        .ex_valid_i(ex_valid), .ex_kind_i(ex_kind), .ex_strict_i(ex_strict),
        .ex_ptr_i(ex_ptr), .ex_seq_i(ex_seq), .ex_lo_i(ex_lo), .ex_hi_i(ex_hi),
        .snp_valid_i(snp_valid), .snp_line_i(snp_line), .viol_ack_i(viol_ack),
        .reexec_o(reexec), .viol_idx_o(viol_idx), .viol_seq_o(viol_seq)
    );

    task automatic check_viol(input logic ev, input logic [IDX_W-1:0] eidx,
                              input logic [SEQ_W-1:0] eseq, input string req);
        n_checks++;
        if (reexec !== ev || (ev && (viol_idx !== eidx || viol_seq !== eseq))) begin
            n_errors++;
            $display("FAIL %s: got reexec=%0b idx=%0d seq=%h, expected reexec=%0b idx=%0d seq=%h",
                     req, reexec, viol_idx, viol_seq, ev, eidx, eseq);
        end
    endtask

    task automatic reset_dut();
        rst = 1; chk_en = 1; flush = 0; alloc = 0; head = 0; tail = 4;
        ex_valid = 0; ex_kind = 0; ex_strict = 0; ex_ptr = 0; ex_seq = 0;
        ex_lo = 0; ex_hi = 0; snp_valid = 0; snp_line = 0; viol_ack = 0;
        repeat (2) @(negedge clk);
        rst = 0;
    endtask

    task automatic exec_op(input logic kind, input logic [IDX_W:0] ptr,
                           input logic [SEQ_W-1:0] seq, input logic [ADDR_W-1:0] lo,
                           input logic [ADDR_W-1:0] hi, input logic strict);
        ex_valid = 1; ex_kind = kind; ex_ptr = ptr; ex_seq = seq;
        ex_lo = lo; ex_hi = hi; ex_strict = strict;
        @(negedge clk);
        ex_valid = 0; ex_strict = 0;
    endtask

    task automatic snoop(input logic [LINE_W-1:0] line);
        snp_valid = 1; snp_line = line;
        @(negedge clk);
        snp_valid = 0;
    endtask

    task automatic ack();
        viol_ack = 1;
        @(negedge clk);
        viol_ack = 0;
    endtask

    task automatic t_reset();
        reset_dut();
        check_viol(0, 0, 0, "R10 reset idle");
    endtask

    task automatic t_store();
        reset_dut();
        exec_op(0, 2, 16'd12, 32'h100, 32'h107, 0);
        check_viol(0, 0, 0, "R5 lone load");
        exec_op(1, 2, 16'd11, 32'h104, 32'h104, 0);
        check_viol(1, 2, 16'd12, "R5 store hits younger load, R12 next edge");
        ack();
        check_viol(0, 0, 0, "R9 ack clears");
        exec_op(1, 3, 16'd13, 32'h104, 32'h104, 0);
        check_viol(0, 0, 0, "R5 older load not checked");
    endtask

    task automatic t_gran();
        reset_dut();
        exec_op(0, 1, 16'd5, 32'h200, 32'h203, 0);
        exec_op(1, 1, 16'd4, 32'h206, 32'h207, 0);
        check_viol(1, 1, 16'd5, "R1 same block");
        ack();
        exec_op(1, 1, 16'd4, 32'h208, 32'h20F, 0);
        check_viol(0, 0, 0, "R1 next block");
    endtask

    task automatic t_bounds();
        reset_dut();
        exec_op(0, 1, 16'd7, 32'h300, 32'h30F, 0);
        exec_op(1, 1, 16'd6, 32'h2F0, 32'h2FF, 0);
        check_viol(0, 0, 0, "R2 ends just below");
        exec_op(1, 1, 16'd6, 32'h2F8, 32'h300, 0);
        check_viol(1, 1, 16'd7, "R2 hi equals load start");
        ack();
        exec_op(1, 1, 16'd6, 32'h308, 32'h320, 0);
        check_viol(1, 1, 16'd7, "R2 lo equals load end");
        ack();
        exec_op(1, 1, 16'd6, 32'h310, 32'h320, 0);
        check_viol(0, 0, 0, "R2 starts just above");
    endtask

    task automatic t_skip();
        reset_dut();
        exec_op(0, 1, 16'd51, 32'hA00, 32'hA07, 1);
        exec_op(1, 0, 16'd50, 32'hA00, 32'hA07, 0);
        check_viol(0, 0, 0, "R3 strict load skipped");
        exec_op(1, 0, 16'd50, 32'h0, 32'h7, 0);
        check_viol(0, 0, 0, "R3 unexecuted slots skipped");
    endtask

    task automatic t_load_load();
        reset_dut();
        exec_op(0, 2, 16'd22, 32'h500, 32'h507, 0);
        exec_op(0, 1, 16'd21, 32'h500, 32'h503, 0);
        check_viol(0, 0, 0, "R4 no snoop flag, only marked");
        snoop(26'h14);
        check_viol(1, 2, 16'd22, "R7 snoop on marked load");
        reset_dut();
        exec_op(0, 2, 16'd22, 32'h540, 32'h547, 0);
        snoop(26'h15);
        check_viol(0, 0, 0, "R7 snoop on unmarked load");
        exec_op(0, 1, 16'd21, 32'h540, 32'h547, 0);
        check_viol(1, 2, 16'd22, "R4 older load after snoop flag");
    endtask

    task automatic t_oldest();
        reset_dut();
        exec_op(0, 1, 16'd31, 32'h600, 32'h607, 0);
        exec_op(0, 3, 16'd33, 32'h700, 32'h707, 0);
        exec_op(1, 0, 16'd30, 32'h700, 32'h700, 0);
        check_viol(1, 3, 16'd33, "R6 first violator");
        exec_op(1, 0, 16'd30, 32'h600, 32'h600, 0);
        check_viol(1, 1, 16'd31, "R6 older replaces");
        exec_op(1, 0, 16'd30, 32'h700, 32'h700, 0);
        check_viol(1, 1, 16'd31, "R6 younger does not replace");
        viol_ack = 1;
        exec_op(1, 0, 16'd30, 32'h700, 32'h700, 0);
        viol_ack = 0;
        check_viol(1, 3, 16'd33, "R9 ack with new violator");
        flush = 1;
        @(negedge clk);
        flush = 0;
        check_viol(0, 0, 0, "R9 flush clears violator");
        exec_op(1, 0, 16'd30, 32'h700, 32'h700, 0);
        check_viol(0, 0, 0, "R9 flush clears records");
        reset_dut();
        exec_op(0, 1, 16'hFFFE, 32'h800, 32'h807, 0);
        exec_op(0, 2, 16'h0001, 32'h810, 32'h817, 0);
        exec_op(1, 0, 16'hFFFD, 32'h800, 32'h8FF, 0);
        check_viol(1, 1, 16'hFFFE, "R6 wrap-safe oldest of two");
    endtask

    task automatic t_enable();
        reset_dut();
        chk_en = 0;
        exec_op(0, 2, 16'd42, 32'h900, 32'h907, 0);
        exec_op(1, 0, 16'd40, 32'h900, 32'h900, 0);
        check_viol(0, 0, 0, "R8 store ignored while disabled");
        snoop(26'h24);
        check_viol(0, 0, 0, "R8 snoop ignored while disabled");
        chk_en = 1;
        exec_op(0, 1, 16'd41, 32'h900, 32'h900, 0);
        check_viol(0, 0, 0, "R8 snoop flag was not set");
        snoop(26'h24);
        check_viol(1, 2, 16'd42, "R8 checks resume");
    endtask

    task automatic t_window();
        reset_dut();
        exec_op(0, 1, 16'd61, 32'hB00, 32'hB07, 0);
        exec_op(1, 0, 16'd60, 32'hB00, 32'hB00, 0);
        check_viol(1, 1, 16'd61, "R11 live slot hit");
        ack();
        head = 2;
        exec_op(1, 2, 16'd62, 32'hB00, 32'hB00, 0);
        check_viol(0, 0, 0, "R11 slot behind head ignored");
        tail = 6;
        exec_op(0, 5, 16'd65, 32'hC00, 32'hC07, 0);
        exec_op(1, 2, 16'd62, 32'hC00, 32'hC00, 0);
        check_viol(1, 5, 16'd65, "R11 live slot after head move");
        ack();
        tail = 5; alloc = 1;
        @(negedge clk);
        alloc = 0; tail = 6;
        exec_op(1, 2, 16'd62, 32'hC00, 32'hC00, 0);
        check_viol(0, 0, 0, "R11 alloc clears slot");
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_store();
        t_gran();
        t_bounds();
        t_skip();
        t_load_load();
        t_oldest();
        t_enable();
        t_window();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule